// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits beside a small 8-bit processor core. It decides which of seven peripheral interrupt requests the core should service next. Every source gets a two-bit priority level, built from one bit in a low-priority register and one bit in a high-priority register. Software can mask the sources one at a time, or all at once through a global enable bit. The controller records each level it has granted in a one-bit-per-level in-service mask. A request at a higher level can therefore interrupt a running handler, and once the core signals a return from that handler, the handler it interrupted becomes the current one again.

Requests are looked at only on machine-cycle ticks. When an eligible request wins, the controller places a fixed vector address on its output and raises an acknowledge. It holds both until the core takes the acknowledge. At that handshake it sends a one-cycle clear pulse back to the peripherals whose request flags are cleared by hardware. Its three control registers sit on a simple byte-wide register bus.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, ackValid and flagClr are 0 and all three registers read 0.
- R2: A write with regWe high loads the register at regAddr. Address 0x10 is the enable register: bit 7 is the global enable and bit i enables source i. Address 0x11 holds the low priority bit of source i in bit i, and address 0x12 holds the high priority bit. Bit 7 of both priority registers reads 0, and any other address reads 0.
- R3: A source whose own enable bit is 0 never wins arbitration, and no source wins while the global enable bit is 0. In either case ackValid stays 0.
- R4: Source i has the level {high bit i, low bit i}, where 3 is the highest level. Of the pending, enabled sources, one at the highest level wins.
- R5: When several winners share the top level, the lowest source index is chosen. The source indices are: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5, counter array = 6.
- R6: While ackValid is high, vecAddr equals 8*i + 3 for the chosen source i.
- R7: Requests are evaluated only at a clock edge where cycleTick is high. If edge k selects a request, ackValid rises after edge k+1. From then until the edge that sees ackTake high, ackValid and vecAddr stay constant.
- R8: A request whose level is at or below the highest level in the in-service mask is not acknowledged.
- R9: A request above the current service level is acknowledged, which preempts the running handler. Each retStrobe pulse removes the highest level from the in-service mask, so the level below it becomes the current service level again.
- R10: In the cycle after the ackTake handshake, flagClr pulses the bit of the granted source if it is timer 0 or timer 1, or if it is external 0 or 1 and the matching extEdge bit (bit 0 for external 0, bit 1 for external 1) is 1. No bit pulses for serial, timer 2 or counter array, or for an external source whose extEdge bit is 0.
- R11: The in-service mask keeps the level a handler was granted at. Rewriting the priority registers afterwards does not change the level that later requests are compared against.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| srcFlag | input | 7 | Raw request flags, one per source index |
| extEdge | input | 2 | Transition-triggered mode of external 0 (bit 0) and external 1 (bit 1) |
| cycleTick | input | 1 | Machine-cycle sampling strobe |
| ackValid | output | 1 | Interrupt acknowledge request to the core |
| vecAddr | output | 8 | Vector address of the granted source |
| ackTake | input | 1 | Core accepts the acknowledge |
| retStrobe | input | 1 | Return-from-interrupt pulse |
| flagClr | output | 7 | One-cycle hardware clear pulse, one per source |

## Verification
If the in-service mask is corrupted, the fault does not appear at once. It shows only at the next tick that carries a request: that request is either acknowledged when it should have been blocked, or blocked when it should have been acknowledged, and ackValid reveals this two cycles after the tick. This is why the bench runs a sequence of preemptions and returns, with a blocked probe request between the steps. A wrong arbitration choice or a wrong held index shows on vecAddr in the first cycle that ackValid is high. A wrong clear policy shows on flagClr in the cycle right after the handshake.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  localparam int NUM_SRC = 7;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int RANK_W  = LVL_W + 1;

  // Source indices whose flag-clear policy is fixed by hardware.
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;

  typedef struct packed {
    logic capture;  // latch the current arbitration winner
    logic grant;    // core took the acknowledge
  } ctlStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_ACK  = 2'd2
  } ctlState_t;

endpackage

// File: rtl/irq_nest_dp.sv
module irq_nest_dp
  import irq_nest_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int VEC_W    = 8,
  parameter int ADDR_EN  = 'h10,
  parameter int ADDR_PLO = 'h11,
  parameter int ADDR_PHI = 'h12,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] srcFlag,
  input  logic [1:0]         extEdge,
  input  ctlStrb_t           strb,
  output logic               candValid,
  output logic [LVL_W-1:0]   candLvl,
  output logic [LVL_W-1:0]   heldLvl,
  output logic [VEC_W-1:0]   vecAddr,
  output logic [NUM_SRC-1:0] flagClr
);

  localparam int GLB_BIT = DATA_W - 1;
  localparam int PAD_W   = DATA_W - NUM_SRC;

  logic [DATA_W-1:0]  enReg;
  logic [NUM_SRC-1:0] prioLo;
  logic [NUM_SRC-1:0] prioHi;
  logic [NUM_SRC-1:0] pendMask;
  logic [NUM_SRC-1:0] clrPolicy;
  logic [LVL_W-1:0]   srcLvl [NUM_SRC];
  logic [IDX_W-1:0]   candIdx;
  logic [IDX_W-1:0]   heldIdx;

  wire selEn  = regWe && (regAddr == ADDR_W'(ADDR_EN));
  wire selPlo = regWe && (regAddr == ADDR_W'(ADDR_PLO));
  wire selPhi = regWe && (regAddr == ADDR_W'(ADDR_PHI));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= '0;
      prioLo <= '0;
      prioHi <= '0;
    end else begin
      if (selEn)  enReg  <= regWdata;
      if (selPlo) prioLo <= regWdata[NUM_SRC-1:0];
      if (selPhi) prioHi <= regWdata[NUM_SRC-1:0];
    end
  end

  always_comb begin
    if (regAddr == ADDR_W'(ADDR_EN))       regRdata = enReg;
    else if (regAddr == ADDR_W'(ADDR_PLO)) regRdata = {{PAD_W{1'b0}}, prioLo};
    else if (regAddr == ADDR_W'(ADDR_PHI)) regRdata = {{PAD_W{1'b0}}, prioHi};
    else                                   regRdata = '0;
  end

  // Level of each source is the pair {high bit, low bit}.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
    assign srcLvl[i] = {prioHi[i], prioLo[i]};
  end

  assign pendMask = srcFlag & enReg[NUM_SRC-1:0] & {NUM_SRC{enReg[GLB_BIT]}};

  // Scan from the highest index down; ">=" lets the lower index win ties.
  always_comb begin
    candValid = 1'b0;
    candLvl   = '0;
    candIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendMask[i] && (!candValid || srcLvl[i] >= candLvl)) begin
        candValid = 1'b1;
        candLvl   = srcLvl[i];
        candIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldIdx <= '0;
      heldLvl <= '0;
    end else if (strb.capture) begin
      heldIdx <= candIdx;
      heldLvl <= candLvl;
    end
  end

  assign vecAddr = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(heldIdx);

  // Which sources get a hardware flag clear on vectoring.
  always_comb begin
    clrPolicy           = '0;
    clrPolicy[SRC_EXT0] = extEdge[0];
    clrPolicy[SRC_EXT1] = extEdge[1];
    clrPolicy[SRC_TMR0] = 1'b1;
    clrPolicy[SRC_TMR1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           flagClr <= '0;
    else if (strb.grant) flagClr <= clrPolicy & (NUM_SRC'(1) << heldIdx);
    else                 flagClr <= '0;
  end

endmodule

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl
  import irq_nest_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycleTick,
  input  logic               candValid,
  input  logic [LVL_W-1:0]   candLvl,
  input  logic [LVL_W-1:0]   heldLvl,
  input  logic               ackTake,
  input  logic               retStrobe,
  output ctlStrb_t           strb,
  output logic               ackValid,
  output logic [NUM_LVL-1:0] svcMask
);

  ctlState_t          state;
  ctlState_t          stateNxt;
  logic [NUM_LVL-1:0] topBit;
  logic [RANK_W-1:0]  curRank;
  logic               eligible;

  // Highest set level: one-hot form and rank (0 = nothing in service).
  always_comb begin
    topBit  = '0;
    curRank = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (svcMask[l]) begin
        topBit    = '0;
        topBit[l] = 1'b1;
        curRank   = RANK_W'(l + 1);
      end
    end
  end

  assign eligible = candValid && ((RANK_W'(candLvl) + RANK_W'(1)) > curRank);

  always_comb begin
    stateNxt     = state;
    strb.capture = 1'b0;
    strb.grant   = 1'b0;
    unique case (state)
      ST_IDLE: if (cycleTick && eligible) begin
        strb.capture = 1'b1;
        stateNxt     = ST_SEL;
      end
      ST_SEL:  stateNxt = ST_ACK;
      ST_ACK:  if (ackTake) begin
        strb.grant = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      svcMask <= '0;
    end else begin
      state   <= stateNxt;
      svcMask <= (svcMask & ~(retStrobe ? topBit : '0))
               | (strb.grant ? (NUM_LVL'(1) << heldLvl) : '0);
    end
  end

  assign ackValid = (state == ST_ACK);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int ADDR_EN  = 'h10,
  parameter int ADDR_PLO = 'h11,
  parameter int ADDR_PHI = 'h12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic [6:0] srcFlag,
  input  logic [1:0] extEdge,
  input  logic       cycleTick,
  output logic       ackValid,
  output logic [7:0] vecAddr,
  input  logic       ackTake,
  input  logic       retStrobe,
  output logic [6:0] flagClr
);

  ctlStrb_t           strb;
  logic               candValid;
  logic [LVL_W-1:0]   candLvl;
  logic [LVL_W-1:0]   heldLvl;
  logic [NUM_LVL-1:0] svcMask;

  irq_nest_dp #(
    .ADDR_W(8), .DATA_W(8), .VEC_W(8),
    .ADDR_EN(ADDR_EN), .ADDR_PLO(ADDR_PLO), .ADDR_PHI(ADDR_PHI),
    .VEC_BASE(3), .VEC_STEP(8)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .srcFlag(srcFlag), .extEdge(extEdge), .strb(strb),
    .candValid(candValid), .candLvl(candLvl), .heldLvl(heldLvl),
    .vecAddr(vecAddr), .flagClr(flagClr)
  );

  irq_nest_ctl uCtl (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick),
    .candValid(candValid), .candLvl(candLvl), .heldLvl(heldLvl),
    .ackTake(ackTake), .retStrobe(retStrobe),
    .strb(strb), .ackValid(ackValid), .svcMask(svcMask)
  );

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cycleTick,
  input logic       ackValid,
  input logic       ackTake,
  input logic       retStrobe,
  input logic [7:0] vecAddr,
  input logic [6:0] flagClr,
  input logic [3:0] svcMask
);

  // R7: acknowledge appears exactly two edges after a selecting tick.
  p_ack_after_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackValid) |-> $past(cycleTick, 2));

  // R7: acknowledge and vector hold until taken.
  p_hold_vec_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !ackTake) |=> (ackValid && $stable(vecAddr)));

  // R6: vector lies on the 8-byte grid starting at 3, within the seven slots.
  p_vec_grid_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (vecAddr[2:0] == 3'd3 && vecAddr <= 8'h33));

  // R10: a clear pulse only follows a handshake and touches one source.
  p_clr_after_take_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr != 7'd0) |-> ($past(ackValid && ackTake) && $onehot0(flagClr)));

  // R10: serial, timer 2 and counter array are never cleared by hardware.
  p_clr_soft_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagClr[6:4] == 3'd0);

  // R8, R9: a grant adds exactly one level, above all levels in service.
  p_grant_higher_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ackValid && ackTake) && !$past(retStrobe)) |->
      (svcMask > $past(svcMask) &&
       $countones(svcMask) == $countones($past(svcMask)) + 1));

  // R9: a return without a grant drops exactly one level.
  p_return_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && svcMask != 4'd0 && !(ackValid && ackTake)) |=>
      ($countones(svcMask) + 1 == $countones($past(svcMask)) &&
       svcMask < $past(svcMask)));

endmodule

bind irq_nest_ctrl irq_nest_chk uChk (
  .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .ackValid(ackValid),
  .ackTake(ackTake), .retStrobe(retStrobe), .vecAddr(vecAddr),
  .flagClr(flagClr), .svcMask(svcMask)
);

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWe;
  logic [7:0] regAddr;
  logic [7:0] regWdata;
  logic [7:0] regRdata;
  logic [6:0] srcFlag;
  logic [1:0] extEdge;
  logic       cycleTick;
  logic       ackValid;
  logic [7:0] vecAddr;
  logic       ackTake;
  logic       retStrobe;
  logic [6:0] flagClr;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_nest_ctrl uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .srcFlag(srcFlag),
    .extEdge(extEdge), .cycleTick(cycleTick), .ackValid(ackValid),
    .vecAddr(vecAddr), .ackTake(ackTake), .retStrobe(retStrobe),
    .flagClr(flagClr)
  );

  typedef struct packed {
    logic [7:0] en;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [6:0] flags;
    logic [1:0] edgeMode;
    logic       expValid;
    logic [7:0] expVec;
    logic [6:0] expClr;
  } vecRow_t;

  localparam int ROWS = 10;
  localparam vecRow_t TABLE [ROWS] = '{
    '{8'h81, 8'h00, 8'h00, 7'b0000001, 2'b01, 1'b1, 8'h03, 7'b0000001},
    '{8'h81, 8'h00, 8'h00, 7'b0000001, 2'b00, 1'b1, 8'h03, 7'b0000000},
    '{8'h01, 8'h00, 8'h00, 7'b0000001, 2'b01, 1'b0, 8'h00, 7'b0000000},
    '{8'hFE, 8'h00, 8'h00, 7'b0000001, 2'b01, 1'b0, 8'h00, 7'b0000000},
    '{8'hFF, 8'h00, 8'h00, 7'b1111111, 2'b00, 1'b1, 8'h03, 7'b0000000},
    '{8'hFF, 8'h10, 8'h00, 7'b1111111, 2'b11, 1'b1, 8'h23, 7'b0000000},
    '{8'hFF, 8'h10, 8'h40, 7'b1111111, 2'b11, 1'b1, 8'h33, 7'b0000000},
    '{8'hFF, 8'h48, 8'h48, 7'b1001000, 2'b00, 1'b1, 8'h1B, 7'b0001000},
    '{8'hFF, 8'h04, 8'h02, 7'b0000110, 2'b11, 1'b1, 8'h0B, 7'b0000010},
    '{8'hA0, 8'h00, 8'h00, 7'b0100000, 2'b00, 1'b1, 8'h2B, 7'b0000000}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1 check(32'(regRdata), 32'(exp), tag);
  endtask

  // Pulse a tick; leaves the bench at the negedge after edge k+1.
  task automatic doTick(input logic expAck, input logic [7:0] expVec, input string tag);
    @(negedge clk); cycleTick = 1'b1;
    @(negedge clk); cycleTick = 1'b0;
    check(32'(ackValid), 32'd0, {tag, " R7 no early ack"});
    @(negedge clk);
    check(32'(ackValid), 32'(expAck), {tag, " ack"});
    if (expAck) check(32'(vecAddr), 32'(expVec), {tag, " vector"});
  endtask

  task automatic takeAck(input logic [6:0] expClr, input string tag);
    ackTake = 1'b1;
    @(negedge clk); ackTake = 1'b0;
    check(32'(flagClr), 32'(expClr), {tag, " R10 clear pulse"});
    check(32'(ackValid), 32'd0, {tag, " ack dropped"});
    @(negedge clk);
    check(32'(flagClr), 32'd0, {tag, " R10 pulse ends"});
  endtask

  task automatic doRet();
    @(negedge clk); retStrobe = 1'b1;
    @(negedge clk); retStrobe = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWe = 1'b0; regAddr = 8'h00; regWdata = 8'h00;
    srcFlag = '0; extEdge = '0; cycleTick = 1'b0; ackTake = 1'b0; retStrobe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check(32'(ackValid), 32'd0, "R1 ackValid");
    check(32'(flagClr), 32'd0, "R1 flagClr");
    rdReg(8'h10, 8'h00, "R1 enable reg");
    rdReg(8'h11, 8'h00, "R1 low prio reg");
    rdReg(8'h12, 8'h00, "R1 high prio reg");

    // R2: register access
    wrReg(8'h10, 8'h5A);
    wrReg(8'h11, 8'hFF);
    wrReg(8'h12, 8'h81);
    wrReg(8'h20, 8'hFF);
    rdReg(8'h10, 8'h5A, "R2 enable readback");
    rdReg(8'h11, 8'h7F, "R2 low prio readback");
    rdReg(8'h12, 8'h01, "R2 high prio readback");
    rdReg(8'h20, 8'h00, "R2 unmapped address");

    // Table walk: R3 R4 R5 R6 R7 R10
    for (int r = 0; r < ROWS; r++) begin
      string tag;
      tag = $sformatf("R3/R4/R5/R6 row %0d", r);
      wrReg(8'h10, TABLE[r].en);
      wrReg(8'h11, TABLE[r].lo);
      wrReg(8'h12, TABLE[r].hi);
      extEdge = TABLE[r].edgeMode;
      srcFlag = TABLE[r].flags;
      doTick(TABLE[r].expValid, TABLE[r].expVec, tag);
      if (TABLE[r].expValid) begin
        @(negedge clk);
        check(32'(ackValid), 32'd1, {tag, " R7 ack held"});
        check(32'(vecAddr), 32'(TABLE[r].expVec), {tag, " R7 vector held"});
        takeAck(TABLE[r].expClr, tag);
        doRet();
      end
      srcFlag = '0;
    end

    // Nesting, preemption and recorded level: R8 R9 R11
    extEdge = 2'b00;
    wrReg(8'h10, 8'hFF);
    wrReg(8'h11, 8'h02);          // timer 0 at level 1
    wrReg(8'h12, 8'h00);
    srcFlag = 7'b0000010;
    doTick(1'b1, 8'h0B, "R9 first handler level 1");
    takeAck(7'b0000010, "R10 timer 0");
    srcFlag = '0;

    wrReg(8'h12, 8'h12);          // timer 0 now level 3, serial level 2
    srcFlag = 7'b0010000;
    doTick(1'b1, 8'h23, "R11 recorded level kept, R9 preempt");
    takeAck(7'b0000000, "R10 serial");
    srcFlag = '0;

    wrReg(8'h12, 8'h13);          // external 0 at level 2
    srcFlag = 7'b0000001;
    doTick(1'b0, 8'h00, "R8 equal level blocked");
    doRet();                      // level 2 leaves service
    doTick(1'b1, 8'h03, "R9 level 2 eligible after return");
    takeAck(7'b0000000, "R10 external 0 level mode");
    srcFlag = '0;

    doRet();                      // back to level 1 only
    srcFlag = 7'b0100000;         // timer 2 at level 0
    doTick(1'b0, 8'h00, "R8 lower level blocked");
    doRet();                      // nothing in service
    doTick(1'b1, 8'h2B, "R9 resumes after final return");
    takeAck(7'b0000000, "R10 timer 2");
    srcFlag = '0;
    doRet();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule